// File: doc/BRIEF.md
# Keyboard Controller Power-Up Sequencer

This block takes a keyboard controller from reset to normal operation. Once reset is released it holds every pin of its control port high for a fixed window, which is 48 cycles of an 8 MHz clock (6 µs). At the end of that window it reads two strap inputs once. If both straps are low it selects PS/2 mode. Otherwise it selects AT mode. It then drives the self-test port pattern for the chosen mode.

The self-test pattern stays fixed until the host issues the self-test command byte 0xAA. On that command the block pulses an output-buffer load carrying the pass byte 0x55. In the same cycle it raises the output-buffer-full pin and pulls the device clock-enable pins low, so the keyboard (and in PS/2 mode also the mouse) can start sending data. Serial protocol handling and scan translation belong to other blocks.

Top module: `kbc_powerup_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block sets `ctl_port` to 0xFF, `seq_state` to 0 (drive), `ps2_mode` to 0 and `obuf_load` to 0.
- R2: After reset is released, `seq_state` stays 0 (drive) and `ctl_port` stays 0xFF for the first 48 clock edges, so bits 3 and 7 are high. On edge 48 `seq_state` becomes 1 (sample), and on edge 49 it becomes 2 (wait).
- R3: On edge 49 the block latches `ps2_mode` as 1 only if `strap_t1` and `strap_p10` are both low. Strap changes after that edge have no effect.
- R4: In AT mode, `ctl_port` becomes 0xCF on edge 49, with bits 4 and 5 low and all other bits high.
- R5: In PS/2 mode, `ctl_port` becomes 0x4B on edge 49, with bits 2, 4, 5 and 7 low and all other bits high.
- R6: A command strobe is ignored in two cases: when its byte is not 0xAA, and when it arrives before state 2 (wait), whatever its byte. In both cases `ctl_port` and `seq_state` stay unchanged and no load occurs.
- R7: A strobe with byte 0xAA in state 2 gives, at the next clock edge, a one-cycle `obuf_load` pulse with `obuf_data` = 0x55 and `ctl_port` bit 4 high.
- R8: In that same edge `seq_state` becomes 3 (run) and `ctl_port` becomes 0x9F in AT mode (bit 6 low), or 0x13 in PS/2 mode (bits 6 and 3 also low).
- R9: In state 3, further strobes (including 0xAA) leave `ctl_port` unchanged and produce no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_t1 | input | 1 | Mode strap A (low together with B selects PS/2) |
| strap_p10 | input | 1 | Mode strap B |
| cmd_valid | input | 1 | Decoded host command strobe, one cycle |
| cmd_byte | input | 8 | Host command byte |
| ctl_port | output | 8 | Control port pin drives (bit n = pin n) |
| ps2_mode | output | 1 | 1 = PS/2 mode latched |
| obuf_load | output | 1 | One-cycle output-buffer load pulse |
| obuf_data | output | 8 | Byte loaded into the output buffer |
| seq_state | output | 2 | 0 drive, 1 sample, 2 wait, 3 run |

## Verification
Each result is due at a fixed edge, counted from reset release or from the strobe. The state must read drive after edges 1 to 47 and sample after edge 48. The mode and the self-test pattern appear after edge 49. A strobe presented before an edge shows its load pulse, run pattern and run state right after that edge, and the pulse must be gone one edge later. The bench changes inputs and samples outputs on falling edges and waits for each exact edge count before checking, so every check lands on the cycle the requirement names.

// File: rtl/kbc_seq_pkg.sv
package kbc_seq_pkg;
  typedef enum logic [1:0] {
    ST_DRIVE  = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_WAIT   = 2'd2,
    ST_RUN    = 2'd3
  } seq_st_e;

  localparam int PORT_W     = 8;
  localparam int PIN_KBINH  = 2;  // low in PS/2 self-test pattern
  localparam int PIN_MSCLK  = 3;  // mouse clock enable, low in PS/2 run
  localparam int PIN_OBF    = 4;  // output buffer full
  localparam int PIN_MSOBF  = 5;  // mouse buffer full
  localparam int PIN_KBCLK  = 6;  // keyboard clock enable, low in run
  localparam int PIN_MSDAT  = 7;  // low in PS/2 self-test pattern

  function automatic logic [PORT_W-1:0] selftest_pattern(input logic ps2);
    logic [PORT_W-1:0] p;
    p = '1;
    p[PIN_OBF]   = 1'b0;
    p[PIN_MSOBF] = 1'b0;
    if (ps2) begin
      p[PIN_KBINH] = 1'b0;
      p[PIN_MSDAT] = 1'b0;
    end
    return p;
  endfunction

  function automatic logic [PORT_W-1:0] run_pattern(input logic ps2,
                                                     input logic [PORT_W-1:0] cur);
    logic [PORT_W-1:0] p;
    p = cur;
    p[PIN_OBF]   = 1'b1;
    p[PIN_KBCLK] = 1'b0;
    if (ps2) p[PIN_MSCLK] = 1'b0;
    return p;
  endfunction
endpackage

// File: rtl/kbc_win_timer.sv
module kbc_win_timer #(
  parameter int WINDOW_CYCLES = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (run && !done) cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST) else $error("counter past window"); // R2
endmodule

// File: rtl/kbc_seq_fsm.sv
module kbc_seq_fsm
  import kbc_seq_pkg::*;
#(
  parameter logic [7:0] CMD_SELFTEST = 8'hAA
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    win_done,
  input  logic    cmd_valid,
  input  logic [7:0] cmd_byte,
  output seq_st_e state,
  output logic    take_selftest
);
  seq_st_e nxt;

  assign take_selftest = (state == ST_WAIT) && cmd_valid && (cmd_byte == CMD_SELFTEST);

  always_comb begin
    nxt = state;
    case (state)
      ST_DRIVE:  if (win_done) nxt = ST_SAMPLE;
      ST_SAMPLE: nxt = ST_WAIT;
      ST_WAIT:   if (take_selftest) nxt = ST_RUN;
      default:   nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_DRIVE;
    else     state <= nxt;
  end

  AST_SAMPLE_AFTER_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SAMPLE) |=> (state == ST_WAIT)) else $error("sample not one cycle"); // R2
  AST_WAIT_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !(cmd_valid && cmd_byte == CMD_SELFTEST)) |=> (state == ST_WAIT))
    else $error("left wait without command"); // R6
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |=> (state == ST_RUN)) else $error("left run"); // R9
endmodule

// File: rtl/kbc_port_drive.sv
module kbc_port_drive
  import kbc_seq_pkg::*;
#(
  parameter logic [7:0] PASS_BYTE = 8'h55
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_st_e           state,
  input  logic              strap_a,
  input  logic              strap_b,
  input  logic              take_selftest,
  output logic [PORT_W-1:0] port,
  output logic              ps2,
  output logic              load,
  output logic [7:0]        load_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      port      <= '1;
      ps2       <= 1'b0;
      load      <= 1'b0;
      load_data <= '0;
    end else begin
      load <= 1'b0;
      if (state == ST_SAMPLE) begin
        ps2  <= !strap_a && !strap_b;
        port <= selftest_pattern(!strap_a && !strap_b);
      end else if (take_selftest) begin
        port      <= run_pattern(ps2, port);
        load      <= 1'b1;
        load_data <= PASS_BYTE;
      end
    end
  end

  AST_DRIVE_PINS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DRIVE) |-> (port[3] && port[7])) else $error("drive pins low"); // R2
  AST_FROZEN_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !take_selftest) |=> $stable(port)) else $error("port moved"); // R6
  AST_LOAD_PASS: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_data == PASS_BYTE && port[PIN_OBF])) else $error("bad load"); // R7
  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
    load |=> !load) else $error("load longer than one cycle"); // R7
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT || state == ST_RUN) |=> $stable(ps2)) else $error("mode changed"); // R3
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !take_selftest) |=> ($stable(port) && !load)) else $error("run moved"); // R9
endmodule

// File: rtl/kbc_powerup_seq.sv
module kbc_powerup_seq
  import kbc_seq_pkg::*;
#(
  parameter int         WINDOW_CYCLES = 48,
  parameter logic [7:0] CMD_SELFTEST  = 8'hAA,
  parameter logic [7:0] PASS_BYTE     = 8'h55
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strap_t1,
  input  logic       strap_p10,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  output logic [7:0] ctl_port,
  output logic       ps2_mode,
  output logic       obuf_load,
  output logic [7:0] obuf_data,
  output logic [1:0] seq_state
);
  seq_st_e st;
  logic    win_done;
  logic    take;

  kbc_win_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (st == ST_DRIVE),
    .done (win_done)
  );

  kbc_seq_fsm #(.CMD_SELFTEST(CMD_SELFTEST)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .win_done      (win_done),
    .cmd_valid     (cmd_valid),
    .cmd_byte      (cmd_byte),
    .state         (st),
    .take_selftest (take)
  );

  kbc_port_drive #(.PASS_BYTE(PASS_BYTE)) u_port (
    .clk           (clk),
    .rst           (rst),
    .state         (st),
    .strap_a       (strap_t1),
    .strap_b       (strap_p10),
    .take_selftest (take),
    .port          (ctl_port),
    .ps2           (ps2_mode),
    .load          (obuf_load),
    .load_data     (obuf_data)
  );

  assign seq_state = st;
endmodule

// File: tb/sim_kbc_powerup_seq.sv
`timescale 1ns/1ps
module sim_kbc_powerup_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strap_t1 = 1'b1, strap_p10 = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [7:0] ctl_port, obuf_data;
  logic       ps2_mode, obuf_load;
  logic [1:0] seq_state;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  kbc_powerup_seq u0 (
    .clk(clk), .rst(rst), .strap_t1(strap_t1), .strap_p10(strap_p10),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .ctl_port(ctl_port),
    .ps2_mode(ps2_mode), .obuf_load(obuf_load), .obuf_data(obuf_data),
    .seq_state(seq_state)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reset, check reset state (R1), release, then walk the window (R2) and mode (R3..R5)
  task automatic boot(input logic t1, input logic p10, input logic [7:0] pat, input logic ps2);
    int bad;
    @(negedge clk); rst = 1'b1; strap_t1 = t1; strap_p10 = p10;
    @(negedge clk); @(negedge clk);
    chk("R1 port", ctl_port, 8'hFF);
    chk("R1 state", {6'b0, seq_state}, 8'd0);
    chk("R1 mode/load", {6'b0, ps2_mode, obuf_load}, 8'd0);
    rst = 1'b0;
    bad = 0;
    for (int k = 1; k <= 47; k++) begin
      @(negedge clk);
      if (seq_state !== 2'd0 || ctl_port !== 8'hFF) bad++;
    end
    chk("R2 drive window", bad[7:0], 8'd0);
    @(negedge clk);
    chk("R2 sample state", {6'b0, seq_state}, 8'd1);
    chk("R2 port in sample", ctl_port, 8'hFF);
    @(negedge clk);
    chk("R2 wait state", {6'b0, seq_state}, 8'd2);
    chk("R3 mode", {7'b0, ps2_mode}, {7'b0, ps2});
    chk(ps2 ? "R5 pattern" : "R4 pattern", ctl_port, pat);
  endtask

  task automatic send(input logic [7:0] b);
    cmd_valid = 1'b1; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_byte = 8'h00;
  endtask

  task automatic selftest(input logic [7:0] run_pat);
    send(8'hAA);
    chk("R7 load", {7'b0, obuf_load}, 8'd1);
    chk("R7 data", obuf_data, 8'h55);
    chk("R8 run pattern", ctl_port, run_pat);
    chk("R8 run state", {6'b0, seq_state}, 8'd3);
    @(negedge clk);
    chk("R7 pulse ends", {7'b0, obuf_load}, 8'd0);
  endtask

  task automatic t_at_mode();
    boot(1'b1, 1'b0, 8'hCF, 1'b0);
    send(8'h00);
    chk("R6 ignore 00", ctl_port, 8'hCF);
    send(8'hAB);
    chk("R6 ignore AB", ctl_port, 8'hCF);
    chk("R6 no load", {7'b0, obuf_load}, 8'd0);
    chk("R6 still wait", {6'b0, seq_state}, 8'd2);
    selftest(8'h9F);
    send(8'hAA);
    chk("R9 no reload", {7'b0, obuf_load}, 8'd0);
    chk("R9 port held", ctl_port, 8'h9F);
  endtask

  task automatic t_ps2_mode();
    boot(1'b0, 1'b0, 8'h4B, 1'b1);
    strap_t1 = 1'b1; strap_p10 = 1'b1;
    @(negedge clk);
    chk("R3 straps ignored later", {7'b0, ps2_mode}, 8'd1);
    selftest(8'h13);
    send(8'h55);
    chk("R9 port held ps2", ctl_port, 8'h13);
  endtask

  task automatic t_other_straps();
    boot(1'b0, 1'b1, 8'hCF, 1'b0);
    boot(1'b1, 1'b1, 8'hCF, 1'b0);
  endtask

  task automatic t_early_cmd();
    @(negedge clk); rst = 1'b1; strap_t1 = 1'b1; strap_p10 = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 10; k++) @(negedge clk);
    send(8'hAA);
    chk("R6 early AA port", ctl_port, 8'hFF);
    chk("R6 early AA load", {7'b0, obuf_load}, 8'd0);
    for (int k = 0; k < 60; k++) @(negedge clk);
    chk("R6 early AA not run", {6'b0, seq_state}, 8'd2);
    chk("R6 early AA pattern", ctl_port, 8'hCF);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_at_mode();
    t_ps2_mode();
    t_other_straps();
    t_early_cmd();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule